// File: doc/BRIEF.md
# Remapping Unit Control Registers

This block is the software-visible register file of a DMA address-remapping unit. Software reads fixed identification and capability words, and it starts actions by writing a global command word. The effect of each action is reported in a separate global status word, not in the command word. The block keeps the root-table address, hands it to the translation engine when software asks for it, and gates translation on and off. It also runs a write-buffer flush handshake.

Two invalidation registers start context-cache and IOTLB invalidations. Writing the go bit sends a one-cycle request pulse to the translation engine, together with the scope, drain and domain fields. The go bit then reads back as 1 and stays busy until the engine returns a done pulse. The IOTLB register is not at a fixed place: it sits one word past the IOTLB group offset that the extended capability advertises. Access uses a simple port with 64-bit words. Writes take effect at the clock edge and reads are combinational.

Top module: `remap_ctrl_regs`

## Requirements
- R1: After reset all state is zero and every engine-facing output is low or zero. Word 0 reads the version in bits [31:0], word 1 reads the capability, and word 2 reads the extended capability with bits [17:8] replaced by the IOTLB group offset parameter.
- R2: Writes to words 0, 1 and 2 are ignored: the values read back afterwards are unchanged.
- R3: Every write to word 3 copies data bit 31 into status bit 31 (read as word 3 bit 63) and into `xlate_en`, so writing 0 there turns translation off. The low half of word 3 reads zero.
- R4: Word 4 holds the root address. Writing word 3 with bit 30 set raises `root_load` for one cycle, loads `root_addr` from word 4 and sets status bit 30 (word 3 bit 62). Writing word 4 clears that status bit and leaves `root_addr` unchanged.
- R5: Writing word 3 with bit 27 set, while capability bit 4 is set and no flush is pending, pulses `flush_req` for one cycle and sets status bit 27 (word 3 bit 59). The bit stays set until `flush_done`, and further flush commands are ignored while it is set.
- R6: Writing word 5 with bit 63 set while it is idle stores bits [62:0] and sets the busy bit, which reads as bit 63. One cycle later `ctx_inv_req` pulses, with `ctx_inv_scope` taken from bits [62:61]. `ctx_inv_done` clears the busy bit. A write with bit 63 clear only stores the fields.
- R7: The IOTLB invalidate word sits at word index 2*offset+1, where offset is the IOTLB group offset parameter. It behaves like word 5, except that the scope comes from bits [61:60], the read drain from bit 49, the write drain from bit 48 and the domain from bits [47:32]. These appear on the `tlb_*` outputs along with a `tlb_inv_req` pulse.
- R8: A write to an invalidation word while it is busy is ignored: there is no pulse and no field change.
- R9: A done pulse that arrives while the matching channel is idle has no effect.
- R10: Word addresses that are not mapped read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 64 | Write data |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_data | output | 64 | Read data (combinational) |
| xlate_en | output | 1 | Translation enable to the engine |
| root_load | output | 1 | One-cycle root-pointer load pulse |
| root_addr | output | 64 | Root address latched for the engine |
| flush_req | output | 1 | One-cycle write-buffer flush request |
| flush_done | input | 1 | Flush completion pulse |
| ctx_inv_req | output | 1 | Context-cache invalidate request pulse |
| ctx_inv_scope | output | 2 | Context invalidation scope |
| ctx_inv_done | input | 1 | Context invalidation completion pulse |
| tlb_inv_req | output | 1 | IOTLB invalidate request pulse |
| tlb_inv_scope | output | 2 | IOTLB scope: 1 global, 2 domain, 3 page |
| tlb_inv_domain | output | 16 | Domain id for the IOTLB invalidation |
| tlb_drain_rd | output | 1 | Drain pending reads |
| tlb_drain_wr | output | 1 | Drain pending writes |
| tlb_inv_done | input | 1 | IOTLB invalidation completion pulse |

## Verification
The command and invalidation paths are first driven by directed sequences. These include enable/disable toggles, a root write before and after the latch command, and a flush command repeated while the first flush is still pending. Each invalidation is written once while idle and once while busy, which separates accepted requests from ignored ones. Done pulses are sent while idle and in the same cycle as a new write, to show which of the two wins. A long random phase then mixes writes to every mapped address, and to some unmapped ones, with random done pulses. Reads sweep all words every cycle, so a field that leaks into the wrong word or the wrong bit shows up in the read data.

// File: rtl/remap_pkg.sv
// Shared constants for the remapping-unit register block.
// Assumes 64-bit register words addressed by word index.
package remap_pkg;
    // Global command and status bit positions (command and status share them)
    localparam int GC_TE   = 31;
    localparam int GC_SRTP = 30;
    localparam int GC_WBF  = 27;
    // Go / busy bit of both invalidation words
    localparam int INV_GO  = 63;
    // Fixed word indices
    localparam int W_VER   = 0;
    localparam int W_CAP   = 1;
    localparam int W_ECAP  = 2;
    localparam int W_GCMD  = 3;
    localparam int W_ROOT  = 4;
    localparam int W_CTX   = 5;
    localparam int N_FIXED = 6;

    // Number of domains for a capability domain-count code; 0 marks the illegal code
    function automatic int unsigned dom_count(input logic [2:0] code);
        if (code == 3'd7) return 0;
        else if (code == 3'd0) return 16;
        else return 32'd16 << (2 * code);
    endfunction
endpackage

// File: rtl/remap_gcmd.sv
// Global command and status logic: translation enable, root pointer latch
// and write-buffer flush handshake. Assumes one register write per cycle
// and a flush_done pulse only after flush_req has been issued.
module remap_gcmd #(
    parameter bit FLUSH_NEEDED = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        gcmd_wr,
    input  logic [31:0] gcmd_data,
    input  logic        root_wr,
    input  logic [63:0] root_data,
    input  logic        flush_done,
    output logic        tes_o,
    output logic        rtps_o,
    output logic        wbfs_o,
    output logic        root_load_o,
    output logic [63:0] root_addr_o,
    output logic        flush_req_o,
    output logic [63:0] root_reg_o
);
    import remap_pkg::*;

    logic [63:0] root_reg_q, root_addr_q;
    logic        tes_q, rtps_q, wbfs_q, load_q, freq_q;

    // Translation enable follows bit 31 of each command write
    always_ff @(posedge clk) begin
        if (!rst_n)       tes_q <= 1'b0;
        else if (gcmd_wr) tes_q <= gcmd_data[GC_TE];
    end

    // Root register, latched copy, load pulse and root status bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root_reg_q  <= '0;
            root_addr_q <= '0;
            rtps_q      <= 1'b0;
            load_q      <= 1'b0;
        end else begin
            load_q <= 1'b0;
            if (root_wr) begin
                root_reg_q <= root_data;
                rtps_q     <= 1'b0;
            end else if (gcmd_wr && gcmd_data[GC_SRTP]) begin
                root_addr_q <= root_reg_q;
                rtps_q      <= 1'b1;
                load_q      <= 1'b1;
            end
        end
    end

    // Flush status: set with a request pulse, cleared by completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbfs_q <= 1'b0;
            freq_q <= 1'b0;
        end else begin
            freq_q <= 1'b0;
            if (FLUSH_NEEDED && gcmd_wr && gcmd_data[GC_WBF] && !wbfs_q) begin
                wbfs_q <= 1'b1;
                freq_q <= 1'b1;
            end else if (wbfs_q && flush_done) begin
                wbfs_q <= 1'b0;
            end
        end
    end

    assign tes_o       = tes_q;
    assign rtps_o      = rtps_q;
    assign wbfs_o      = wbfs_q;
    assign root_load_o = load_q;
    assign root_addr_o = root_addr_q;
    assign flush_req_o = freq_q;
    assign root_reg_o  = root_reg_q;

    // R3: enable status reflects the bit of the previous command write
    a_r3_te_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gcmd_wr) |-> tes_o == $past(gcmd_data[GC_TE]));
    // R4: the engine-facing root address moves only with a load pulse
    a_r4_root_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !root_load_o |-> $stable(root_addr_o));
    // R5: flush status drops only after a completion pulse
    a_r5_flush_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wbfs_o) |-> $past(flush_done));
    // R5: a flush request is a single-cycle pulse
    a_r5_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req_o |=> !flush_req_o);
endmodule

// File: rtl/remap_inval.sv
// One invalidation channel: stores the written fields, raises a busy bit
// and a one-cycle request when the go bit is written while idle, and drops
// busy on the engine's done pulse. Writes while busy and done while idle
// are ignored.
module remap_inval #(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              done,
    output logic              busy_o,
    output logic [DATA_W-2:0] cfg_o,
    output logic              req_o
);
    logic              busy_q, req_q;
    logic [DATA_W-2:0] cfg_q;

    // Accept writes only while idle; completion clears busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            req_q  <= 1'b0;
            cfg_q  <= '0;
        end else begin
            req_q <= 1'b0;
            if (wr_hit && !busy_q) begin
                cfg_q <= wr_data[DATA_W-2:0];
                if (wr_data[DATA_W-1]) begin
                    busy_q <= 1'b1;
                    req_q  <= 1'b1;
                end
            end else if (busy_q && done) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign busy_o = busy_q;
    assign cfg_o  = cfg_q;
    assign req_o  = req_q;

    // R6/R7: busy clears only on a done pulse
    a_r6_busy_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(done));
    // R8: a request is only issued from the idle state
    a_r8_req_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> (busy_o && !$past(busy_o)));
    // R8: request is a single-cycle pulse
    a_r8_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);
    // R9: an idle channel stays idle without a new request
    a_r9_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !(wr_hit && wr_data[DATA_W-1])) |=> !busy_o);
endmodule

// File: rtl/remap_ctrl_regs.sv
// Register block of a DMA remapping unit: address decode, combinational
// read mux, global command/status and two invalidation channels.
// Assumes at most one write per cycle and full 64-bit word accesses.
module remap_ctrl_regs #(
    parameter logic [31:0] VERSION    = 32'h0000_0010,
    parameter logic [63:0] CAP_VALUE  = 64'h0000_0004_0000_0412,
    parameter logic [63:0] ECAP_VALUE = 64'h0000_0000_0000_0005,
    parameter int          TLB_OFS    = 16,
    parameter int          ADDR_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [63:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [63:0]       rd_data,
    output logic              xlate_en,
    output logic              root_load,
    output logic [63:0]       root_addr,
    output logic              flush_req,
    input  logic              flush_done,
    output logic              ctx_inv_req,
    output logic [1:0]        ctx_inv_scope,
    input  logic              ctx_inv_done,
    output logic              tlb_inv_req,
    output logic [1:0]        tlb_inv_scope,
    output logic [15:0]       tlb_inv_domain,
    output logic              tlb_drain_rd,
    output logic              tlb_drain_wr,
    input  logic              tlb_inv_done
);
    import remap_pkg::*;

    localparam int          TLB_WORD  = 2 * TLB_OFS + 1;
    localparam logic [63:0] IRO_MASK  = 64'h0000_0000_0003_FF00;
    localparam logic [63:0] ECAP_WORD = (ECAP_VALUE & ~IRO_MASK) |
                                        ((64'(TLB_OFS) << 8) & IRO_MASK);

    // Elaboration-time sanity of parameters
    initial begin
        a_cfg_domains: assert (dom_count(CAP_VALUE[2:0]) != 0)
            else $error("illegal domain-count code");
        a_cfg_tlb_word: assert (TLB_WORD >= N_FIXED && TLB_WORD < (1 << ADDR_W))
            else $error("IOTLB word overlaps fixed words or exceeds address range");
    end

    logic        gcmd_hit, root_hit, ctx_hit, tlb_hit;
    logic        tes, rtps, wbfs;
    logic [63:0] root_reg;
    logic        ctx_busy, tlb_busy;
    logic [62:0] ctx_cfg, tlb_cfg;

    // Write decode
    always_comb begin
        gcmd_hit = wr_en && (wr_addr == ADDR_W'(W_GCMD));
        root_hit = wr_en && (wr_addr == ADDR_W'(W_ROOT));
        ctx_hit  = wr_en && (wr_addr == ADDR_W'(W_CTX));
        tlb_hit  = wr_en && (wr_addr == ADDR_W'(TLB_WORD));
    end

    remap_gcmd #(.FLUSH_NEEDED(CAP_VALUE[4])) u_gcmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .gcmd_wr    (gcmd_hit),
        .gcmd_data  (wr_data[31:0]),
        .root_wr    (root_hit),
        .root_data  (wr_data),
        .flush_done (flush_done),
        .tes_o      (tes),
        .rtps_o     (rtps),
        .wbfs_o     (wbfs),
        .root_load_o(root_load),
        .root_addr_o(root_addr),
        .flush_req_o(flush_req),
        .root_reg_o (root_reg)
    );

    remap_inval #(.DATA_W(64)) u_ctx (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (ctx_hit),
        .wr_data(wr_data),
        .done   (ctx_inv_done),
        .busy_o (ctx_busy),
        .cfg_o  (ctx_cfg),
        .req_o  (ctx_inv_req)
    );

    remap_inval #(.DATA_W(64)) u_tlb (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (tlb_hit),
        .wr_data(wr_data),
        .done   (tlb_inv_done),
        .busy_o (tlb_busy),
        .cfg_o  (tlb_cfg),
        .req_o  (tlb_inv_req)
    );

    // Engine-facing field extraction
    always_comb begin
        xlate_en       = tes;
        ctx_inv_scope  = ctx_cfg[62:61];
        tlb_inv_scope  = tlb_cfg[61:60];
        tlb_drain_rd   = tlb_cfg[49];
        tlb_drain_wr   = tlb_cfg[48];
        tlb_inv_domain = tlb_cfg[47:32];
    end

    // Read mux; status sits in the upper half of the command word
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(W_VER))       rd_data = {32'h0, VERSION};
        else if (rd_addr == ADDR_W'(W_CAP))  rd_data = CAP_VALUE;
        else if (rd_addr == ADDR_W'(W_ECAP)) rd_data = ECAP_WORD;
        else if (rd_addr == ADDR_W'(W_GCMD)) begin
            rd_data[32 + GC_TE]   = tes;
            rd_data[32 + GC_SRTP] = rtps;
            rd_data[32 + GC_WBF]  = wbfs;
        end
        else if (rd_addr == ADDR_W'(W_ROOT))   rd_data = root_reg;
        else if (rd_addr == ADDR_W'(W_CTX))    rd_data = {ctx_busy, ctx_cfg};
        else if (rd_addr == ADDR_W'(TLB_WORD)) rd_data = {tlb_busy, tlb_cfg};
    end

    // R7: an IOTLB request carries the fields of the accepted write
    a_r7_tlb_fields: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_inv_req |-> tlb_inv_domain == $past(wr_data[47:32]));
    // R6: context request carries the written scope
    a_r6_ctx_scope: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_inv_req |-> ctx_inv_scope == $past(wr_data[62:61]));
endmodule

// File: tb/remap_ctrl_regs_test.sv
module remap_ctrl_regs_test;
    localparam int          AW      = 6;
    localparam int          TLB_W   = 33;
    localparam logic [63:0] CAP     = 64'h0000_0004_0000_0412;
    localparam logic [63:0] ECAP_RD = 64'h0000_0000_0000_1005;
    localparam logic [31:0] VER     = 32'h0000_0010;

    logic clk = 0;
    logic rst_n = 0;
    logic wr_en = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [63:0] wr_data = '0;
    logic flush_done = 0, ctx_inv_done = 0, tlb_inv_done = 0;
    logic [63:0] rd_data, root_addr;
    logic xlate_en, root_load, flush_req, ctx_inv_req, tlb_inv_req;
    logic [1:0] ctx_inv_scope, tlb_inv_scope;
    logic [15:0] tlb_inv_domain;
    logic tlb_drain_rd, tlb_drain_wr;

    always #2.5 clk = ~clk;

    remap_ctrl_regs uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .xlate_en(xlate_en), .root_load(root_load), .root_addr(root_addr),
        .flush_req(flush_req), .flush_done(flush_done),
        .ctx_inv_req(ctx_inv_req), .ctx_inv_scope(ctx_inv_scope),
        .ctx_inv_done(ctx_inv_done), .tlb_inv_req(tlb_inv_req),
        .tlb_inv_scope(tlb_inv_scope), .tlb_inv_domain(tlb_inv_domain),
        .tlb_drain_rd(tlb_drain_rd), .tlb_drain_wr(tlb_drain_wr),
        .tlb_inv_done(tlb_inv_done)
    );

    int n_vec = 0, n_bad = 0;
    string tag = "R1";
    bit finished = 0;

    // Behavioural reference state
    bit m_tes, m_rtps, m_wbfs, m_load, m_freq;
    logic [63:0] m_root_reg, m_root_out;
    bit m_cb, m_tb, m_creq, m_treq;
    logic [62:0] m_ccfg, m_tcfg;

    // Reference model updated on each rising edge from the sampled inputs
    always @(posedge clk) begin
        bit wb0, cb0, tb0;
        if (!rst_n) begin
            m_tes = 0; m_rtps = 0; m_wbfs = 0; m_load = 0; m_freq = 0;
            m_root_reg = 0; m_root_out = 0;
            m_cb = 0; m_tb = 0; m_creq = 0; m_treq = 0; m_ccfg = 0; m_tcfg = 0;
        end else begin
            wb0 = m_wbfs; cb0 = m_cb; tb0 = m_tb;
            m_load = 0; m_freq = 0; m_creq = 0; m_treq = 0;
            if (wr_en) begin
                if (wr_addr == 3) begin
                    m_tes = wr_data[31];
                    if (wr_data[30]) begin
                        m_root_out = m_root_reg; m_load = 1; m_rtps = 1;
                    end
                    if (wr_data[27] && !wb0) begin
                        m_wbfs = 1; m_freq = 1;
                    end
                end else if (wr_addr == 4) begin
                    m_root_reg = wr_data; m_rtps = 0;
                end else if (wr_addr == 5 && !cb0) begin
                    m_ccfg = wr_data[62:0];
                    if (wr_data[63]) begin m_cb = 1; m_creq = 1; end
                end else if (wr_addr == TLB_W && !tb0) begin
                    m_tcfg = wr_data[62:0];
                    if (wr_data[63]) begin m_tb = 1; m_treq = 1; end
                end
            end
            if (flush_done && wb0) m_wbfs = 0;
            if (ctx_inv_done && cb0) m_cb = 0;
            if (tlb_inv_done && tb0) m_tb = 0;
        end
    end

    function automatic logic [63:0] exp_rd(input int a);
        case (a)
            0: return {32'h0, VER};
            1: return CAP;
            2: return ECAP_RD;
            3: return {m_tes, m_rtps, 2'b00, m_wbfs, 27'h0, 32'h0};
            4: return m_root_reg;
            5: return {m_cb, m_ccfg};
            TLB_W: return {m_tb, m_tcfg};
            default: return 64'h0;
        endcase
    endfunction

    task automatic check(input string f, input logic [63:0] got, input logic [63:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %h expected %h", tag, f, got, exp);
        end
    endtask

    // Compare every output one step after each rising edge
    always @(posedge clk) begin
        #1;
        if (!finished) begin
            check("rd_data", rd_data, exp_rd(int'(rd_addr)));
            check("xlate_en", 64'(xlate_en), 64'(m_tes));
            check("root_load", 64'(root_load), 64'(m_load));
            check("root_addr", root_addr, m_root_out);
            check("flush_req", 64'(flush_req), 64'(m_freq));
            check("ctx_inv_req", 64'(ctx_inv_req), 64'(m_creq));
            check("ctx_inv_scope", 64'(ctx_inv_scope), 64'(m_ccfg[62:61]));
            check("tlb_inv_req", 64'(tlb_inv_req), 64'(m_treq));
            check("tlb_inv_scope", 64'(tlb_inv_scope), 64'(m_tcfg[61:60]));
            check("tlb_inv_domain", 64'(tlb_inv_domain), 64'(m_tcfg[47:32]));
            check("tlb_drain", 64'({tlb_drain_rd, tlb_drain_wr}), 64'(m_tcfg[49:48]));
        end
    end

    // Read address sweeps all words, including unmapped ones (R10)
    int sweep = 0;
    always @(negedge clk) begin
        int list [9] = '{0, 1, 2, 3, 4, 5, TLB_W, 6, 40};
        rd_addr <= AW'(list[sweep]);
        sweep <= (sweep + 1) % 9;
    end

    task automatic wr(input int a, input logic [63:0] d);
        @(negedge clk); wr_en = 1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic done_pulse(input int which);
        @(negedge clk);
        flush_done = (which == 0); ctx_inv_done = (which == 1); tlb_inv_done = (which == 2);
        @(negedge clk);
        flush_done = 0; ctx_inv_done = 0; tlb_inv_done = 0;
    endtask

    task automatic summary;
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        tag = "R1"; idle(12); rst_n = 1; idle(10);
        tag = "R2";
        wr(0, '1); wr(1, '1); wr(2, 64'h0); idle(10);
        tag = "R10";
        wr(6, 64'hDEAD_BEEF_0123_4567); wr(40, '1); idle(10);
        tag = "R3";
        wr(3, 64'h8000_0000); idle(9); wr(3, 64'h0); idle(9); wr(3, 64'h8000_0000); idle(9);
        tag = "R4";
        wr(4, 64'h0000_00AB_CDEF_1000); idle(9);
        wr(3, 64'hC000_0000); idle(9);
        wr(4, 64'h0000_0012_3456_7000); idle(9);
        wr(3, 64'hC000_0000); idle(9);
        tag = "R5";
        wr(3, 64'h8800_0000); idle(3); wr(3, 64'h8800_0000); idle(9);
        done_pulse(0); idle(9); wr(3, 64'h8800_0000); idle(4); done_pulse(0); idle(9);
        tag = "R6";
        wr(5, 64'h2000_0000_0000_0000); idle(9);
        wr(5, 64'hA000_0000_0000_0000); idle(9); done_pulse(1); idle(9);
        tag = "R7";
        wr(TLB_W, 64'hA003_1234_0000_0000); idle(9); done_pulse(2); idle(9);
        wr(TLB_W, 64'hB000_00FF_0000_0000); idle(9); done_pulse(2); idle(9);
        tag = "R8";
        wr(5, 64'hC000_0000_0000_0000); wr(5, 64'hA000_0000_0000_0001); idle(9);
        wr(TLB_W, 64'h9002_0001_0000_0000); wr(TLB_W, 64'hB001_0002_0000_0000); idle(9);
        @(negedge clk); wr_en = 1; wr_addr = 5; wr_data = 64'hE000_0000_0000_0000; ctx_inv_done = 1;
        @(negedge clk); wr_en = 0; ctx_inv_done = 0; idle(9);
        done_pulse(2); idle(9);
        tag = "R9";
        done_pulse(0); done_pulse(1); done_pulse(2); idle(9);
        tag = "R6";
        wr(5, 64'hA000_0000_0000_0000); idle(3); done_pulse(1); idle(9);
        tag = "R8";
        for (int i = 0; i < 3000; i++) begin
            int pick;
            int addrs [7] = '{0, 3, 4, 5, TLB_W, 6, 2};
            @(negedge clk);
            pick = $urandom % 7;
            wr_en = ($urandom % 2) == 1;
            wr_addr = AW'(addrs[pick]);
            wr_data = {$urandom, $urandom};
            flush_done = ($urandom % 4) == 0;
            ctx_inv_done = ($urandom % 4) == 0;
            tlb_inv_done = ($urandom % 4) == 0;
        end
        @(negedge clk);
        wr_en = 0; flush_done = 0; ctx_inv_done = 0; tlb_inv_done = 0;
        tag = "R1"; rst_n = 0; idle(3); rst_n = 1; idle(10);
        summary();
    end
endmodule